// File: doc/BRIEF.md
# Serial Control Register Port

This block takes write-only control traffic for an audio converter over three wires and an active-low select: a data line, a shift clock and a load strobe. While the select is low, each rising edge of the shift clock moves one data bit into a 16-bit shift register, most significant bit first. A rising edge on the load strobe, also taken only while the select is low, hands the word to a decoder. The decoder reads a 3-bit address from bits 11:9 and a 9-bit payload from bits 8:0. Bits 15:12 carry nothing.

The payload updates one of five control registers, and every control field is a separate output. Five registers are defined. Two hold the attenuation for each channel. One holds the data-format controls and one holds the processing controls. The last holds the output routing, and it stays write-protected until a specific unlock pattern has been written into the format register.

All four serial inputs are brought into the system clock domain through a synchroniser chain, and their edges are found there. The outputs are plain registers that hold their value until the next accepted write.

Top module: `ctl3w_port`

## Requirements
- R1: After reset both attenuation outputs read 0xFF and every other control output reads 0.
- R2: A frame is shifted most significant bit first on rising shift-clock edges. When more than 16 bits arrive before the load strobe, only the last 16 count.
- R3: Shift-clock edges and load-strobe edges are ignored while the select input is high. Outputs change only when a frame is accepted.
- R4: Address 000 loads the left load flag from payload bit 8 and the left attenuation from bits 7:0. Address 001 loads the right flag and attenuation from the same positions. Frame bits 15:12 have no effect.
- R5: Address 010 loads the word-length code from bits 4:3, output disable from bit 2, de-emphasis enable from bit 1 and mute from bit 0.
- R6: Address 011 loads the following fields:
  - bit 8: zero-detect enable
  - bits 7:6: de-emphasis rate code (00 none, 01 48 kHz, 10 44.1 kHz, 11 32 kHz)
  - bit 5: clock-out divide-by-two
  - bit 4: phase reverse
  - bit 3: slow roll-off
  - bit 2: common attenuation
  - bit 1: word-clock polarity
  - bit 0: I2S select
- R7: Address 110 loads the clock-loss-detector disable from bit 6 and the output-mode code from bits 5:4. The mode codes are 00 stereo, 01 swapped stereo, 10 mono left differential and 11 mono right differential.
- R8: A write to address 110 is accepted only while unlocked. The port is unlocked when the most recent write to address 010 carried 1111 in payload bits 8:5. Any later write to address 010 without that pattern locks the port again.
- R9: Frames addressed to 100, 101 or 111 leave every output unchanged.
- R10: An accepted frame shows on the outputs at the third system clock edge after the load strobe rises: two synchroniser stages, then one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock |
| ser_load | input | 1 | Load strobe, rising edge commits |
| ser_sel_n | input | 1 | Active-low select |
| att_left | output | 8 | Left attenuation code |
| att_right | output | 8 | Right attenuation code |
| load_left | output | 1 | Left load flag |
| load_right | output | 1 | Right load flag |
| word_len | output | 2 | Word-length code |
| out_disable | output | 1 | Output forced to zero |
| deemph_en | output | 1 | De-emphasis enable |
| soft_mute | output | 1 | Soft mute |
| zero_det_en | output | 1 | Zero-detect enable |
| deemph_rate | output | 2 | De-emphasis rate code |
| clkout_div2 | output | 1 | Clock output divided by two |
| phase_rev | output | 1 | Output phase reversed |
| slow_rolloff | output | 1 | Slow filter roll-off |
| common_att | output | 1 | Left attenuation used for both channels |
| wclk_pol | output | 1 | Word-clock polarity |
| i2s_sel | output | 1 | I2S format select |
| clkdet_dis | output | 1 | Clock-loss detector disable |
| out_mode | output | 2 | Output routing mode code |

## Verification
The assertions check three things on every cycle. The outputs hold still when no frame is committed. Undefined addresses, and the routing register while it is locked, never change an output. An accepted write to the attenuation or format register puts the payload on those outputs one cycle later.

Some behaviour depends on the serial timing and on write order, so only the bench scenarios can show it:
- bit order and the last-sixteen-bits rule
- the select gating shift and load separately
- locking again after a plain format write
- the exact three-edge latency

A behavioural reference model in the bench, which delays the input samples through a queue, is compared with all outputs on every clock.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int FRAME_W  = 16;
  localparam int ADDR_W   = 3;
  localparam int PAY_W    = 9;
  localparam int ADDR_LSB = PAY_W;

  localparam logic [ADDR_W-1:0] A_LEFT  = 3'b000;
  localparam logic [ADDR_W-1:0] A_RIGHT = 3'b001;
  localparam logic [ADDR_W-1:0] A_FMT   = 3'b010;
  localparam logic [ADDR_W-1:0] A_PROC  = 3'b011;
  localparam logic [ADDR_W-1:0] A_OUT   = 3'b110;

  localparam logic [3:0] UNLOCK_KEY = 4'hF;

  function automatic logic [ADDR_W-1:0] frame_addr(input logic [FRAME_W-1:0] w);
    return w[ADDR_LSB +: ADDR_W];
  endfunction

  function automatic logic [PAY_W-1:0] frame_payload(input logic [FRAME_W-1:0] w);
    return w[PAY_W-1:0];
  endfunction

  function automatic logic carries_key(input logic [PAY_W-1:0] p);
    return p[8:5] == UNLOCK_KEY;
  endfunction

  function automatic logic addr_defined(input logic [ADDR_W-1:0] a);
    return (a == A_LEFT) || (a == A_RIGHT) || (a == A_FMT) ||
           (a == A_PROC) || (a == A_OUT);
  endfunction
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= IDLE;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= IDLE;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ctl3w_frame_rx.sv
module ctl3w_frame_rx
  import ctl3w_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               data_s,
  input  logic               sclk_s,
  input  logic               load_s,
  input  logic               sel_n_s,
  output logic [FRAME_W-1:0] word,
  output logic               commit
);
  logic sclk_d, load_d;
  logic shift_ev, load_rise;

  assign shift_ev  = sclk_s & ~sclk_d & ~sel_n_s;
  assign load_rise = load_s & ~load_d;
  assign commit    = load_rise & ~sel_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      load_d <= 1'b0;
      word   <= '0;
    end else begin
      sclk_d <= sclk_s;
      load_d <= load_s;
      if (shift_ev) word <= {word[FRAME_W-2:0], data_s};
    end
  end

  AST_IDLE_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n_s && $stable(sel_n_s)) |=> $stable(word)); // R3
endmodule

// File: rtl/ctl3w_regfile.sv
module ctl3w_regfile
  import ctl3w_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [FRAME_W-1:0] word,
  output logic [7:0]         att_left,
  output logic [7:0]         att_right,
  output logic               load_left,
  output logic               load_right,
  output logic [1:0]         word_len,
  output logic               out_disable,
  output logic               deemph_en,
  output logic               soft_mute,
  output logic               zero_det_en,
  output logic [1:0]         deemph_rate,
  output logic               clkout_div2,
  output logic               phase_rev,
  output logic               slow_rolloff,
  output logic               common_att,
  output logic               wclk_pol,
  output logic               i2s_sel,
  output logic               clkdet_dis,
  output logic [1:0]         out_mode
);
  logic [ADDR_W-1:0] wr_addr;
  logic [PAY_W-1:0]  wr_pay;
  logic [8:0] left_q, right_q, proc_q;
  logic [4:0] fmt_q;
  logic [2:0] route_q;
  logic       unlocked;
  logic       wr_route_blocked, wr_undefined;

  assign wr_addr = frame_addr(word);
  assign wr_pay  = frame_payload(word);
  assign wr_route_blocked = commit && (wr_addr == A_OUT) && !unlocked;
  assign wr_undefined     = commit && !addr_defined(wr_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q   <= 9'h0FF;
      right_q  <= 9'h0FF;
      fmt_q    <= '0;
      proc_q   <= '0;
      route_q  <= '0;
      unlocked <= 1'b0;
    end else if (commit) begin
      case (wr_addr)
        A_LEFT:  left_q  <= wr_pay;
        A_RIGHT: right_q <= wr_pay;
        A_FMT: begin
          fmt_q    <= wr_pay[4:0];
          unlocked <= carries_key(wr_pay);
        end
        A_PROC:  proc_q  <= wr_pay;
        A_OUT:   if (unlocked) route_q <= wr_pay[6:4];
        default: ;
      endcase
    end
  end

  assign load_left    = left_q[8];
  assign att_left     = left_q[7:0];
  assign load_right   = right_q[8];
  assign att_right    = right_q[7:0];
  assign word_len     = fmt_q[4:3];
  assign out_disable  = fmt_q[2];
  assign deemph_en    = fmt_q[1];
  assign soft_mute    = fmt_q[0];
  assign zero_det_en  = proc_q[8];
  assign deemph_rate  = proc_q[7:6];
  assign clkout_div2  = proc_q[5];
  assign phase_rev    = proc_q[4];
  assign slow_rolloff = proc_q[3];
  assign common_att   = proc_q[2];
  assign wclk_pol     = proc_q[1];
  assign i2s_sel      = proc_q[0];
  assign clkdet_dis   = route_q[2];
  assign out_mode     = route_q[1:0];

  logic [34:0] all_out;
  assign all_out = {att_left, att_right, load_left, load_right, word_len,
                    out_disable, deemph_en, soft_mute, zero_det_en, deemph_rate,
                    clkout_div2, phase_rev, slow_rolloff, common_att, wclk_pol,
                    i2s_sel, clkdet_dis, out_mode};

  AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(all_out)); // R3
  AST_LEFT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wr_addr == A_LEFT) |=> (att_left == $past(wr_pay[7:0]))); // R4
  AST_FMT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wr_addr == A_FMT) |=>
      ({word_len, out_disable, deemph_en, soft_mute} == $past(wr_pay[4:0]))); // R5
  AST_ROUTE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_route_blocked |=> $stable({clkdet_dis, out_mode})); // R8
  AST_UNDEF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_undefined |=> $stable(all_out)); // R9
endmodule

// File: rtl/ctl3w_port.sv
module ctl3w_port
  import ctl3w_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_data,
  input  logic       ser_clk,
  input  logic       ser_load,
  input  logic       ser_sel_n,
  output logic [7:0] att_left,
  output logic [7:0] att_right,
  output logic       load_left,
  output logic       load_right,
  output logic [1:0] word_len,
  output logic       out_disable,
  output logic       deemph_en,
  output logic       soft_mute,
  output logic       zero_det_en,
  output logic [1:0] deemph_rate,
  output logic       clkout_div2,
  output logic       phase_rev,
  output logic       slow_rolloff,
  output logic       common_att,
  output logic       wclk_pol,
  output logic       i2s_sel,
  output logic       clkdet_dis,
  output logic [1:0] out_mode
);
  logic [3:0] raw_in, sync_out;
  logic [FRAME_W-1:0] rx_word;
  logic rx_commit;

  assign raw_in = {ser_sel_n, ser_load, ser_clk, ser_data};

  ctl3w_sync #(.W(4), .STAGES(SYNC_STAGES), .IDLE(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  ctl3w_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .data_s(sync_out[0]), .sclk_s(sync_out[1]),
    .load_s(sync_out[2]), .sel_n_s(sync_out[3]),
    .word(rx_word), .commit(rx_commit)
  );

  ctl3w_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .commit(rx_commit), .word(rx_word),
    .att_left(att_left), .att_right(att_right),
    .load_left(load_left), .load_right(load_right),
    .word_len(word_len), .out_disable(out_disable),
    .deemph_en(deemph_en), .soft_mute(soft_mute),
    .zero_det_en(zero_det_en), .deemph_rate(deemph_rate),
    .clkout_div2(clkout_div2), .phase_rev(phase_rev),
    .slow_rolloff(slow_rolloff), .common_att(common_att),
    .wclk_pol(wclk_pol), .i2s_sel(i2s_sel),
    .clkdet_dis(clkdet_dis), .out_mode(out_mode)
  );
endmodule

// File: tb/tb_ctl3w_port.sv
`timescale 1ns/1ps
module tb_ctl3w_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_load = 1'b0, ser_sel_n = 1'b1;
  logic [7:0] att_left, att_right;
  logic load_left, load_right, out_disable, deemph_en, soft_mute, zero_det_en;
  logic clkout_div2, phase_rev, slow_rolloff, common_att, wclk_pol, i2s_sel, clkdet_dis;
  logic [1:0] word_len, deemph_rate, out_mode;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ctl3w_port dut (.*);

  function automatic logic [34:0] observed();
    return {att_left, att_right, load_left, load_right, word_len, out_disable,
            deemph_en, soft_mute, zero_det_en, deemph_rate, clkout_div2, phase_rev,
            slow_rolloff, common_att, wclk_pol, i2s_sel, clkdet_dis, out_mode};
  endfunction

  // Reference model: input samples delayed in a queue, registers kept as plain variables
  logic [3:0] hist[$];
  logic [15:0] m_shift;
  logic [8:0] m_left, m_right, m_fmt, m_proc, m_route;
  bit m_unlocked;

  function automatic logic [34:0] expected();
    return {m_left[7:0], m_right[7:0], m_left[8], m_right[8], m_fmt[4:3], m_fmt[2],
            m_fmt[1], m_fmt[0], m_proc[8], m_proc[7:6], m_proc[5], m_proc[4],
            m_proc[3], m_proc[2], m_proc[1], m_proc[0], m_route[6], m_route[5:4]};
  endfunction

  task automatic model_reset();
    hist = {4'b1000, 4'b1000, 4'b1000};
    m_shift = 0; m_left = 9'h0FF; m_right = 9'h0FF;
    m_fmt = 0; m_proc = 0; m_route = 0; m_unlocked = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      logic [3:0] cur, prv;
      int a; logic [8:0] p;
      cur = hist[1]; prv = hist[2];
      if (cur[2] && !prv[2] && !cur[3]) begin
        a = m_shift[11:9]; p = m_shift[8:0];
        if (a == 0) m_left = p;
        else if (a == 1) m_right = p;
        else if (a == 2) begin m_fmt = p; m_unlocked = (p[8:5] == 4'hF); end
        else if (a == 3) m_proc = p;
        else if (a == 6 && m_unlocked) m_route = p;
      end
      if (cur[1] && !prv[1] && !cur[3]) m_shift = {m_shift[14:0], cur[0]};
      hist.push_front({ser_sel_n, ser_load, ser_clk, ser_data});
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (observed() !== expected()) begin
      errors++;
      $display("FAIL R10 model compare at %0t: actual=%h expected=%h", $time, observed(), expected());
    end
  end

  task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = v[i]; waitn(3);
      ser_clk = 1'b1; waitn(3);
      ser_clk = 1'b0;
    end
  endtask

  task automatic pulse_load();
    ser_load = 1'b1; waitn(3);
    ser_load = 1'b0; waitn(3);
  endtask

  task automatic write_frame(input logic [15:0] w);
    ser_sel_n = 1'b0; waitn(2);
    shift_bits({16'h0, w}, 16);
    pulse_load();
    ser_sel_n = 1'b1; waitn(4);
  endtask

  function automatic logic [15:0] frm(input logic [3:0] junk, input logic [2:0] a, input logic [8:0] p);
    return {junk, a, p};
  endfunction

  initial begin
    logic [34:0] snap;
    waitn(4); rst_n = 1'b1; waitn(2);
    check("R1 reset attenuation", {19'h0, att_left, att_right}, {19'h0, 16'hFFFF});
    check("R1 reset others", {16'h0, observed()} & 35'h7FFFF, 35'h0);

    write_frame(frm(4'hA, 3'b000, 9'h15A));
    check("R4 left write", {26'h0, load_left, att_left}, {26'h0, 1'b1, 8'h5A});
    write_frame(frm(4'h5, 3'b001, 9'h0C3));
    check("R4 right write", {26'h0, load_right, att_right}, {26'h0, 1'b0, 8'hC3});

    write_frame(frm(4'h0, 3'b010, 9'h01B));
    check("R5 format fields", {30'h0, word_len, out_disable, deemph_en, soft_mute},
          {30'h0, 5'b11011});

    write_frame(frm(4'h0, 3'b110, 9'h070));
    check("R8 locked route write", {32'h0, clkdet_dis, out_mode}, 35'h0);

    write_frame(frm(4'h0, 3'b010, 9'h1E5));
    write_frame(frm(4'h0, 3'b110, 9'h060));
    check("R7 unlocked route write", {32'h0, clkdet_dis, out_mode}, {32'h0, 3'b110});

    write_frame(frm(4'h0, 3'b010, 9'h000));
    write_frame(frm(4'h0, 3'b110, 9'h030));
    check("R8 relocked route write", {32'h0, clkdet_dis, out_mode}, {32'h0, 3'b110});

    write_frame(frm(4'h3, 3'b011, 9'h1A5));
    check("R6 processing fields", {26'h0, zero_det_en, deemph_rate, clkout_div2, phase_rev,
          slow_rolloff, common_att, wclk_pol, i2s_sel}, {26'h0, 9'h1A5});

    snap = observed();
    write_frame(frm(4'h0, 3'b100, 9'h1FF));
    write_frame(frm(4'h0, 3'b101, 9'h1FF));
    write_frame(frm(4'h0, 3'b111, 9'h1FF));
    check("R9 undefined addresses", observed(), snap);

    ser_sel_n = 1'b1; waitn(2);
    shift_bits({16'h0, frm(4'h0, 3'b000, 9'h011)}, 16);
    pulse_load(); waitn(4);
    check("R3 select high frame", observed(), snap);

    ser_sel_n = 1'b0; waitn(2);
    shift_bits({16'h0, frm(4'h0, 3'b000, 9'h022)}, 16);
    ser_sel_n = 1'b1; waitn(2);
    pulse_load(); waitn(4);
    check("R3 load with select high", observed(), snap);

    ser_sel_n = 1'b0; waitn(2);
    shift_bits(32'h000D_0000 | {16'h0, frm(4'h0, 3'b001, 9'h081)}, 20);
    pulse_load(); ser_sel_n = 1'b1; waitn(4);
    check("R2 last sixteen bits", {26'h0, load_right, att_right}, {26'h0, 1'b0, 8'h81});

    ser_sel_n = 1'b0; waitn(2);
    shift_bits({16'h0, frm(4'h0, 3'b000, 9'h03C)}, 16);
    ser_load = 1'b1; waitn(2);
    check("R10 no change after two edges", {27'h0, att_left}, {27'h0, 8'h5A});
    waitn(1);
    check("R10 change at third edge", {27'h0, att_left}, {27'h0, 8'h3C});
    waitn(2); ser_load = 1'b0; waitn(3); ser_sel_n = 1'b1; waitn(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule